// File: doc/BRIEF.md
# Grouped Popcount Action Head

This block turns the last binary layer of a logic-gate policy network into signed fixed-point action means. The incoming bit vector is split into equal, disjoint groups, one per action dimension. The block counts the ones in each group and maps every count through that dimension's affine transform (scale times count plus offset, clamped to the signed output range). The mapping needs no multiplier. Each action owns a small table with one entry per possible count, and the table is filled by repeated addition when a dimension is configured.

A controller with three named states sequences the work. In `ST_IDLE` nothing is in flight. A configuration request (`cfg_valid`) moves it to `ST_LOAD` and an input (`in_valid`) moves it to `ST_RUN`. If both arrive in the same cycle, the configuration wins. `ST_LOAD` writes entries 0 through GROUP_W of the selected action's table, one per cycle, and then returns to `ST_IDLE`. `ST_RUN` accepts an input on every cycle that `in_valid` is high. It returns to `ST_IDLE` after a cycle that has no input and an empty count stage. In each row, count and lookup are registered stages, so a result appears two cycles after its input.

Top module: `popcount_action_head`

## Requirements
- R1: After reset `out_valid` is 0, `out_action` is all zeros and every table entry is 0, so inputs processed before any configuration give all-zero actions.
- R2: Group a is `in_bits[a*GROUP_W +: GROUP_W]` and its action is `out_action[a*OUT_W +: OUT_W]`, two's complement. Groups never influence one another.
- R3: An accepted input produces exactly one `out_valid` pulse two cycles later. Inputs on consecutive cycles produce outputs on consecutive cycles, in order.
- R4: Each action equals offset + scale × (number of ones in its group), clamped to [-32768, 32767] for OUT_W = 16.
- R5: A group with no bits set yields exactly its offset.
- R6: A group with every bit set yields offset + scale × GROUP_W after clamping, and positive and negative overflow saturate to the extreme values.
- R7: A `cfg_valid` accepted in `ST_IDLE` loads the table of action `cfg_act` from `cfg_scale` and `cfg_offset` over GROUP_W+1 cycles in `ST_LOAD`, starting at entry 0. The tables of the other actions are unchanged.
- R8: `cfg_valid` is ignored outside `ST_IDLE`, including while inputs are streaming in `ST_RUN`.
- R9: `in_valid` is ignored during `ST_LOAD` and in the cycle a configuration is accepted. Such inputs produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit vector is valid |
| in_bits | input | NUM_ACT*GROUP_W | Final binary layer, grouped per action |
| cfg_valid | input | 1 | Request to load one action's table |
| cfg_act | input | ACT_W | Action index to configure |
| cfg_scale | input | COEF_W | Signed scale per set bit |
| cfg_offset | input | COEF_W | Signed offset at zero count |
| out_valid | output | 1 | Action vector is valid |
| out_action | output | NUM_ACT*OUT_W | Signed action means, packed per action |

## Verification
The bench goes after the table ends: empty and full groups, and counts whose affine value overflows in either direction. A design with an off-by-one fill, or one without clamping, would return a wrapped or shifted value there. It streams inputs back to back and checks both the two-cycle spacing and the ordering, which an extra or missing stage or a lost beat would break. Configuration is issued while the block is streaming, and inputs are issued while it is loading or together with a configuration request. A design that does not gate these would either corrupt a table mid-stream or emit outputs the scoreboard never expected. Reconfiguring a single action and then checking all four catches writes that land in the wrong table.

// File: rtl/pah_pkg.sv
package pah_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } pah_state_e;

endpackage

// File: rtl/pah_popcount.sv
module pah_popcount #(
    parameter int NUM_ACT = 4,
    parameter int GROUP_W = 16,
    parameter int CNT_W   = $clog2(GROUP_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_fire,
    input  logic [NUM_ACT*GROUP_W-1:0] in_bits,
    output logic                       cnt_valid,
    output logic [NUM_ACT*CNT_W-1:0]   cnt_flat
);

    function automatic logic [CNT_W-1:0] ones_in(input logic [GROUP_W-1:0] v);
        logic [CNT_W-1:0] sum;
        sum = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            sum = sum + CNT_W'(v[i]);
        end
        return sum;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_valid <= 1'b0;
        end else begin
            cnt_valid <= in_fire;
        end
    end

    for (genvar g = 0; g < NUM_ACT; g++) begin : g_grp
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (in_fire) begin
                cnt_q <= ones_in(in_bits[g*GROUP_W +: GROUP_W]);
            end
        end

        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;

        // R4
        cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_valid |-> (cnt_q <= CNT_W'(GROUP_W)));
    end

endmodule

// File: rtl/pah_table.sv
module pah_table #(
    parameter int NUM_ACT = 4,
    parameter int GROUP_W = 16,
    parameter int OUT_W   = 16,
    parameter int CNT_W   = $clog2(GROUP_W + 1),
    parameter int ACT_W   = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ACT_W-1:0]         wr_act,
    input  logic [CNT_W-1:0]         wr_addr,
    input  logic [OUT_W-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [NUM_ACT*CNT_W-1:0] rd_cnt,
    output logic                     out_valid,
    output logic [NUM_ACT*OUT_W-1:0] out_action
);

    localparam int DEPTH = GROUP_W + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= rd_en;
        end
    end

    for (genvar a = 0; a < NUM_ACT; a++) begin : g_row
        logic [OUT_W-1:0] entry [DEPTH];
        logic [OUT_W-1:0] act_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    entry[i] <= '0;
                end
            end else if (wr_en && (wr_act == ACT_W'(a))) begin
                entry[wr_addr] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (rd_en) begin
                act_q <= entry[rd_cnt[a*CNT_W +: CNT_W]];
            end
        end

        assign out_action[a*OUT_W +: OUT_W] = act_q;
    end

    // R9
    wr_rd_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);

endmodule

// File: rtl/pah_ctrl.sv
module pah_ctrl
    import pah_pkg::*;
#(
    parameter int NUM_ACT = 4,
    parameter int GROUP_W = 16,
    parameter int OUT_W   = 16,
    parameter int COEF_W  = 16,
    parameter int CNT_W   = $clog2(GROUP_W + 1),
    parameter int ACT_W   = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     cfg_valid,
    input  logic [ACT_W-1:0]         cfg_act,
    input  logic signed [COEF_W-1:0] cfg_scale,
    input  logic signed [COEF_W-1:0] cfg_offset,
    input  logic                     cnt_valid,
    output logic                     in_fire,
    output logic                     wr_en,
    output logic [ACT_W-1:0]         wr_act,
    output logic [CNT_W-1:0]         wr_addr,
    output logic [OUT_W-1:0]         wr_data
);

    localparam int ACC_W = COEF_W + CNT_W + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    pah_state_e              state_q, state_d;
    logic [ACT_W-1:0]        act_q;
    logic [CNT_W-1:0]        idx_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] step_q;
    logic                    cfg_take;
    logic                    load_last;

    assign cfg_take  = (state_q == ST_IDLE) && cfg_valid;
    assign load_last = (idx_q == CNT_W'(GROUP_W));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_valid)     state_d = ST_LOAD;
                else if (in_valid) state_d = ST_RUN;
            end
            ST_LOAD: begin
                if (load_last) state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (!in_valid && !cnt_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_fire = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: in_fire = in_valid && !cfg_valid;
            ST_LOAD: wr_en   = 1'b1;
            ST_RUN:  in_fire = in_valid;
            default: begin
                in_fire = 1'b0;
                wr_en   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            idx_q  <= '0;
            acc_q  <= '0;
            step_q <= '0;
        end else if (cfg_take) begin
            act_q  <= cfg_act;
            idx_q  <= '0;
            acc_q  <= ACC_W'(cfg_offset);
            step_q <= ACC_W'(cfg_scale);
        end else if (state_q == ST_LOAD) begin
            idx_q <= idx_q + 1'b1;
            acc_q <= acc_q + step_q;
        end
    end

    always_comb begin
        if (acc_q > SAT_HI)      wr_data = SAT_HI[OUT_W-1:0];
        else if (acc_q < SAT_LO) wr_data = SAT_LO[OUT_W-1:0];
        else                     wr_data = acc_q[OUT_W-1:0];
    end

    assign wr_act  = act_q;
    assign wr_addr = idx_q;

    // R7
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (wr_addr == '0));

    // R7
    load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R8
    cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && state_q == ST_RUN) |=> !wr_en);

endmodule

// File: rtl/popcount_action_head.sv
module popcount_action_head #(
    parameter int NUM_ACT = 4,
    parameter int GROUP_W = 16,
    parameter int OUT_W   = 16,
    parameter int COEF_W  = 16,
    parameter int ACT_W   = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_ACT*GROUP_W-1:0] in_bits,
    input  logic                       cfg_valid,
    input  logic [ACT_W-1:0]           cfg_act,
    input  logic signed [COEF_W-1:0]   cfg_scale,
    input  logic signed [COEF_W-1:0]   cfg_offset,
    output logic                       out_valid,
    output logic [NUM_ACT*OUT_W-1:0]   out_action
);

    localparam int CNT_W = $clog2(GROUP_W + 1);

    logic                     in_fire;
    logic                     cnt_valid;
    logic [NUM_ACT*CNT_W-1:0] cnt_flat;
    logic                     wr_en;
    logic [ACT_W-1:0]         wr_act;
    logic [CNT_W-1:0]         wr_addr;
    logic [OUT_W-1:0]         wr_data;

    pah_ctrl #(
        .NUM_ACT(NUM_ACT), .GROUP_W(GROUP_W), .OUT_W(OUT_W),
        .COEF_W(COEF_W), .CNT_W(CNT_W), .ACT_W(ACT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cfg_valid(cfg_valid), .cfg_act(cfg_act),
        .cfg_scale(cfg_scale), .cfg_offset(cfg_offset),
        .cnt_valid(cnt_valid), .in_fire(in_fire),
        .wr_en(wr_en), .wr_act(wr_act), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    pah_popcount #(
        .NUM_ACT(NUM_ACT), .GROUP_W(GROUP_W), .CNT_W(CNT_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_bits(in_bits),
        .cnt_valid(cnt_valid), .cnt_flat(cnt_flat)
    );

    pah_table #(
        .NUM_ACT(NUM_ACT), .GROUP_W(GROUP_W), .OUT_W(OUT_W),
        .CNT_W(CNT_W), .ACT_W(ACT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_act(wr_act),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(cnt_valid),
        .rd_cnt(cnt_flat), .out_valid(out_valid), .out_action(out_action)
    );

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> ##1 out_valid);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_fire, 2));

    // R9
    load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !cnt_valid);

endmodule

// File: tb/popcount_action_head_test.sv
module popcount_action_head_test;

    localparam int NA = 4;
    localparam int GW = 16;
    localparam int OW = 16;
    localparam int CW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [NA*GW-1:0]     in_bits = '0;
    logic                 cfg_valid = 1'b0;
    logic [1:0]           cfg_act = '0;
    logic signed [CW-1:0] cfg_scale = '0;
    logic signed [CW-1:0] cfg_offset = '0;
    logic                 out_valid;
    logic [NA*OW-1:0]     out_action;

    int n_checks = 0;
    int n_fail = 0;
    int m_scale [NA];
    int m_off   [NA];
    logic [NA*OW-1:0] exp_q [$];
    string            tag_q [$];

    always #2 clk = ~clk;

    popcount_action_head uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .cfg_valid(cfg_valid), .cfg_act(cfg_act), .cfg_scale(cfg_scale),
        .cfg_offset(cfg_offset), .out_valid(out_valid), .out_action(out_action)
    );

    function automatic logic [OW-1:0] clamp(input int v);
        if (v > 32767)  return 16'h7fff;
        if (v < -32768) return 16'h8000;
        return OW'(v);
    endfunction

    function automatic logic [NA*OW-1:0] model(input logic [NA*GW-1:0] b);
        logic [NA*OW-1:0] r;
        for (int a = 0; a < NA; a++) begin
            r[a*OW +: OW] = clamp(m_off[a] + m_scale[a] * $countones(b[a*GW +: GW]));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NA*OW-1:0] act,
                         input logic [NA*OW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one input beat per call, expected value queued when it will be accepted.
    task automatic send(input logic [NA*GW-1:0] b, input string tag, input bit expect_out);
        in_valid = 1'b1;
        in_bits  = b;
        if (expect_out) begin
            exp_q.push_back(model(b));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid  = 1'b0;
        cfg_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input int a, input int s, input int o);
        cfg_valid  = 1'b1;
        cfg_act    = 2'(a);
        cfg_scale  = CW'(s);
        cfg_offset = CW'(o);
        m_scale[a] = s;
        m_off[a]   = o;
        @(negedge clk);
        cfg_valid = 1'b0;
        idle(GW + 4);
    endtask

    function automatic logic [NA*GW-1:0] fill(input int c0, input int c1,
                                              input int c2, input int c3);
        logic [NA*GW-1:0] r;
        int c [NA];
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        r = '0;
        for (int a = 0; a < NA; a++) begin
            for (int i = 0; i < c[a]; i++) r[a*GW + i] = 1'b1;
        end
        return r;
    endfunction

    // Monitor: compare each result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9: unexpected output %h expected none", out_action);
            end else begin
                check(tag_q.pop_front(), out_action, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) begin
            m_scale[a] = 0;
            m_off[a]   = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", {63'd0, out_valid}, '0);
        check("R1 reset out_action", out_action, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 unconfigured tables give zero
        send(fill(3, 16, 0, 9), "R1 zero tables", 1'b1);
        idle(5);

        configure(0, 100, -500);
        configure(1, -3, 7);
        configure(2, 3000, 1000);
        configure(3, -4000, -100);

        // R5 empty groups
        send('0, "R5 all zero groups", 1'b1);
        idle(4);
        // R6 full groups, both saturation directions
        send('1, "R6 all ones groups", 1'b1);
        idle(4);
        // R2 distinct counts per group
        send(fill(1, 2, 3, 4), "R2 group partition", 1'b1);
        send(fill(16, 0, 10, 8), "R2 group partition b", 1'b1);
        idle(4);
        // R6 saturation edge for action 2 (count 10 in range, 11 clamps)
        send(fill(0, 0, 10, 0), "R6 below clamp", 1'b1);
        send(fill(0, 0, 11, 9), "R6 at clamp", 1'b1);
        idle(4);

        // R3 latency: single beat, valid exactly two edges later
        send(fill(5, 5, 5, 5), "R3 latency value", 1'b1);
        check("R3 not early", {63'd0, out_valid}, '0);
        @(negedge clk);
        check("R3 on time", {63'd0, out_valid}, 64'd1);
        idle(4);

        // R4 R3 back-to-back random stream
        for (int k = 0; k < 24; k++) begin
            logic [NA*GW-1:0] b;
            b = {$urandom(), $urandom()};
            send(b, "R4 stream", 1'b1);
        end
        idle(6);

        // R8 config while streaming is ignored
        send(fill(2, 2, 2, 2), "R8 stream before", 1'b1);
        cfg_valid = 1'b1; cfg_act = 2'd0; cfg_scale = 16'sd9; cfg_offset = 16'sd9;
        send(fill(4, 4, 4, 4), "R8 stream during", 1'b1);
        cfg_valid = 1'b0;
        idle(GW + 4);
        send(fill(7, 1, 0, 16), "R8 table kept", 1'b1);
        idle(5);

        // R9 input in same cycle as accepted config is dropped
        cfg_valid = 1'b1; cfg_act = 2'd1; cfg_scale = 16'sd250; cfg_offset = -16'sd20;
        m_scale[1] = 250; m_off[1] = -20;
        send(fill(1, 1, 1, 1), "R9 same cycle", 1'b0);
        cfg_valid = 1'b0;
        // R9 input during load is dropped
        send(fill(9, 9, 9, 9), "R9 during load", 1'b0);
        idle(GW + 4);

        // R7 only action 1 changed
        send(fill(16, 16, 0, 3), "R7 other actions kept", 1'b1);
        send(fill(0, 13, 6, 12), "R7 reloaded action", 1'b1);
        idle(6);

        // R7 reload action 3 to a positive mapping
        configure(3, 2047, 0);
        send('1, "R7 R6 reload full", 1'b1);
        send('0, "R7 R5 reload empty", 1'b1);
        idle(6);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3: %0d outputs missing, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule